// File: doc/BRIEF.md
# Programmable Parallel Port with Strobed Handshake

This block gives a processor bus 24 programmable lines. It has two 8-bit data ports, A and B, and an 8-bit port C. Port C is split into two nibbles: the upper nibble belongs to group A and the lower nibble belongs to group B. Two address bits select port A, port B, port C or the control register. Bus accesses are synchronous single-cycle strobes. Reads return data combinationally in the same cycle, and the side effect of a read takes place at the clock edge that ends it.

Each group runs in one of two modes. In plain mode the port is a latched output or a direct input. In strobed mode three port C lines of the group become handshake lines: a strobe or acknowledge input, a buffer-full output and an interrupt output.

Each group has its own handshake state machine with these states: `HS_OFF` (plain mode), `IN_EMPTY`, `IN_LATCHED`, `IN_FULL`, `OUT_IDLE`, `OUT_FULL`, `OUT_ACKING` and `OUT_DONE`. A mode write moves the machine to `HS_OFF`, `IN_EMPTY` or `OUT_IDLE`. The input transitions are:
- `IN_EMPTY` to `IN_LATCHED` on a strobe fall.
- `IN_LATCHED` to `IN_FULL` when the strobe rises.
- `IN_LATCHED` or `IN_FULL` to `IN_EMPTY` on a port read.
- `IN_FULL` to `IN_LATCHED` on a fresh strobe fall.

The output transitions are:
- Any output state to `OUT_FULL` on a port write.
- `OUT_FULL` to `OUT_ACKING` when the acknowledge goes low.
- `OUT_ACKING` to `OUT_DONE` when the acknowledge goes high again.

Top module: `hsp_port`

## Requirements
- R1: After reset every line is an input (all output enables 0), port C output values are 0, both groups are in plain mode and both interrupt enables are off.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A read of address 3 returns 0.
- R3: In plain mode an input port reads its pins live. An output port drives the last value written to it, sets its enables to all ones, and reads back that written value.
- R4: A control write with bit 7 = 1 sets the configuration. Any nonzero value in bits 6..5 selects strobed mode for group A. Bit 4 = 1 makes port A an input. Bit 3 = 1 makes PC7..4 inputs. Bit 2 = 1 selects strobed mode for group B. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes PC3..0 inputs. The same write clears the port A, B and C output latches and returns the handshake to its idle state.
- R5: A control write with bit 7 = 0 writes bit 0 into the port C latch bit numbered by bits 3..1. Latch bit 4 is the group A interrupt enable and latch bit 0 is the group B interrupt enable.
- R6: A port C read returns the driven value on lines whose enable is 1 and the pin value on lines whose enable is 0.
- R7: In strobed mode, group A takes its strobe or acknowledge on PC4, drives its buffer-full line on PC5 and drives its interrupt on PC6. Group B uses PC0, PC1 and PC2 in the same roles.
- R8: In strobed input, a low strobe after a high one latches the port pins and sets buffer-full (high) at that clock edge. A port read then returns the latched value, not the live pins.
- R9: The input interrupt equals buffer-full AND strobe high AND enable. A port read clears both buffer-full and the interrupt at the clock edge that ends the read.
- R10: In strobed output, a port write drives the active-low buffer-full line low at that edge. The first edge that sees acknowledge low returns the line high.
- R11: If enabled, the output interrupt rises at the edge after the acknowledge returns high. It holds until the next port write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C drive value |
| pc_oe | output | 8 | Port C drive enables |

## Verification
A handshake machine in the wrong state shows at the port C pins by the next clock edge. The buffer-full line or the interrupt line has the wrong level, and in input mode the interrupt line can be wrong within the same cycle, because it follows the strobe pin combinationally. A wrong latched value or a stale configuration shows on the first port read or the first look at the enables after the write that should have changed them. The bench therefore samples the handshake lines on the cycle after each strobe, acknowledge or bus access.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int NGRP     = 2;
    localparam int ADDR_W   = 2;
    localparam int PCW      = 8;

    localparam logic [ADDR_W-1:0] SEL_PA  = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_PB  = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_PC  = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CTL = 2'd3;

    typedef enum logic [2:0] {
        HS_OFF,
        IN_EMPTY,
        IN_LATCHED,
        IN_FULL,
        OUT_IDLE,
        OUT_FULL,
        OUT_ACKING,
        OUT_DONE
    } hs_state_e;

    // port C pin roles per group (group 0 = A, group 1 = B)
    function automatic int hs_in_bit(input int g);
        return (g == 0) ? 4 : 0;
    endfunction

    function automatic int hs_flag_bit(input int g);
        return (g == 0) ? 5 : 1;
    endfunction

    function automatic int hs_int_bit(input int g);
        return (g == 0) ? 6 : 2;
    endfunction

endpackage

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
    import hsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [NGRP-1:0]   wr_grp,
    output logic [NGRP-1:0]   rd_grp,
    output logic              cfg_load,
    output logic [NGRP-1:0]   cfg_mode1,
    output logic [NGRP-1:0]   cfg_dir_in,
    output logic [PCW-1:0]    pc_latch,
    output logic              pc_hi_in,
    output logic              pc_lo_in
);

    localparam int BIT_SEL_W = $clog2(PCW);

    logic ctl_wr;
    logic bsr_wr;
    logic pc_wr;
    logic [BIT_SEL_W-1:0] bsr_idx;

    assign ctl_wr  = wr_en && (addr == SEL_CTL);
    assign cfg_load = ctl_wr && wdata[7];
    assign bsr_wr  = ctl_wr && !wdata[7];
    assign pc_wr   = wr_en && (addr == SEL_PC);
    assign bsr_idx = wdata[BIT_SEL_W:1];

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            wr_grp[g] = wr_en && (addr == ADDR_W'(g));
            rd_grp[g] = rd_en && (addr == ADDR_W'(g));
        end
        cfg_mode1[0]  = |wdata[6:5];
        cfg_dir_in[0] = wdata[4];
        cfg_mode1[1]  = wdata[2];
        cfg_dir_in[1] = wdata[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_latch <= '0;
            pc_hi_in <= 1'b1;
            pc_lo_in <= 1'b1;
        end else if (cfg_load) begin
            pc_latch <= '0;
            pc_hi_in <= wdata[3];
            pc_lo_in <= wdata[0];
        end else if (bsr_wr) begin
            pc_latch[bsr_idx] <= wdata[0];
        end else if (pc_wr) begin
            pc_latch <= wdata[PCW-1:0];
        end
    end

    a_r5_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_CTL && !wdata[7]) |=>
            (pc_latch[$past(wdata[3:1])] == $past(wdata[0])));

    a_r4_mode_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_CTL && wdata[7]) |=> (pc_latch == '0));

endmodule

// File: rtl/hsp_group.sv
module hsp_group
    import hsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_mode1,
    input  logic          cfg_dir_in,
    input  logic          wr_port,
    input  logic          rd_port,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    input  logic          hs_in,
    input  logic          inte,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    output logic          mode1_o,
    output logic          flag_pin,
    output logic          intr
);

    hs_state_e state, state_nx;
    logic          mode1_q;
    logic          dir_in_q;
    logic [DW-1:0] out_q;
    logic [DW-1:0] in_q;
    logic          hs_prev;
    logic          hs_fall;
    logic          ibf;
    logic          obf_n;

    assign hs_fall = hs_prev && !hs_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (cfg_load) begin
            state_nx = !cfg_mode1 ? HS_OFF : (cfg_dir_in ? IN_EMPTY : OUT_IDLE);
        end else begin
            unique case (state)
                HS_OFF:     state_nx = HS_OFF;
                IN_EMPTY:   if (hs_fall) state_nx = IN_LATCHED;
                IN_LATCHED: if (rd_port) state_nx = IN_EMPTY;
                            else if (hs_in) state_nx = IN_FULL;
                IN_FULL:    if (rd_port) state_nx = IN_EMPTY;
                            else if (hs_fall) state_nx = IN_LATCHED;
                OUT_IDLE:   if (wr_port) state_nx = OUT_FULL;
                OUT_FULL:   if (!wr_port && !hs_in) state_nx = OUT_ACKING;
                OUT_ACKING: if (wr_port) state_nx = OUT_FULL;
                            else if (hs_in) state_nx = OUT_DONE;
                OUT_DONE:   if (wr_port) state_nx = OUT_FULL;
                default:    state_nx = HS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode1_q  <= 1'b0;
            dir_in_q <= 1'b1;
            out_q    <= '0;
            in_q     <= '0;
            hs_prev  <= 1'b1;
        end else begin
            hs_prev <= hs_in;
            if (cfg_load) begin
                mode1_q  <= cfg_mode1;
                dir_in_q <= cfg_dir_in;
                out_q    <= '0;
                in_q     <= '0;
            end else begin
                if (wr_port) out_q <= wdata;
                if (state_nx == IN_LATCHED && state != IN_LATCHED) in_q <= pin_in;
            end
        end
    end

    always_comb begin
        ibf      = (state == IN_LATCHED) || (state == IN_FULL);
        obf_n    = (state != OUT_FULL);
        flag_pin = dir_in_q ? ibf : obf_n;
        intr     = inte && ((ibf && hs_in) || (state == OUT_DONE));
        pin_out  = out_q;
        pin_oe   = {DW{!dir_in_q}};
        mode1_o  = mode1_q;
        if (!dir_in_q)    rd_val = out_q;
        else if (mode1_q) rd_val = in_q;
        else              rd_val = pin_in;
    end

    a_r8_full_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_q && dir_in_q && !cfg_load && !rd_port && hs_prev && !hs_in) |=> flag_pin);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_q && dir_in_q && !cfg_load && rd_port && !(hs_prev && !hs_in)) |=> !flag_pin);

    a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_q && !dir_in_q && !cfg_load && wr_port) |=> !flag_pin);

    a_r10_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_q && !dir_in_q && !cfg_load && !wr_port && !flag_pin && !hs_in) |=> flag_pin);

    a_r11_intr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_q && !dir_in_q && !cfg_load && !wr_port && intr && inte) |=> (intr || !inte));

endmodule

// File: rtl/hsp_port.sv
module hsp_port
    import hsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic [DW-1:0]     pa_oe,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic [DW-1:0]     pb_oe,
    input  logic [PCW-1:0]    pc_in,
    output logic [PCW-1:0]    pc_out,
    output logic [PCW-1:0]    pc_oe
);

    localparam int HALF = PCW / 2;

    logic [NGRP-1:0] wr_grp, rd_grp, cfg_mode1, cfg_dir_in;
    logic [NGRP-1:0] grp_mode1, grp_flag, grp_intr;
    logic            cfg_load, pc_hi_in, pc_lo_in;
    logic [PCW-1:0]  pc_latch;
    logic [DW-1:0]   grp_pin_in [NGRP];
    logic [DW-1:0]   grp_rd     [NGRP];
    logic [DW-1:0]   grp_out    [NGRP];
    logic [DW-1:0]   grp_oe     [NGRP];

    hsp_ctrl #(.DW(DW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .wr_grp(wr_grp), .rd_grp(rd_grp), .cfg_load(cfg_load),
        .cfg_mode1(cfg_mode1), .cfg_dir_in(cfg_dir_in), .pc_latch(pc_latch),
        .pc_hi_in(pc_hi_in), .pc_lo_in(pc_lo_in)
    );

    assign grp_pin_in[0] = pa_in;
    assign grp_pin_in[1] = pb_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        hsp_group #(.DW(DW)) grp_i (
            .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
            .cfg_mode1(cfg_mode1[g]), .cfg_dir_in(cfg_dir_in[g]),
            .wr_port(wr_grp[g]), .rd_port(rd_grp[g]), .wdata(wdata),
            .pin_in(grp_pin_in[g]), .hs_in(pc_in[hs_in_bit(g)]),
            .inte(pc_latch[hs_in_bit(g)]), .rd_val(grp_rd[g]),
            .pin_out(grp_out[g]), .pin_oe(grp_oe[g]), .mode1_o(grp_mode1[g]),
            .flag_pin(grp_flag[g]), .intr(grp_intr[g])
        );
    end

    assign pa_out = grp_out[0];
    assign pa_oe  = grp_oe[0];
    assign pb_out = grp_out[1];
    assign pb_oe  = grp_oe[1];

    always_comb begin
        pc_oe  = {{HALF{!pc_hi_in}}, {HALF{!pc_lo_in}}};
        pc_out = pc_latch;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_mode1[g]) begin
                pc_oe[hs_in_bit(g)]    = 1'b0;
                pc_oe[hs_flag_bit(g)]  = 1'b1;
                pc_oe[hs_int_bit(g)]   = 1'b1;
                pc_out[hs_flag_bit(g)] = grp_flag[g];
                pc_out[hs_int_bit(g)]  = grp_intr[g];
            end
        end
    end

    always_comb begin
        unique case (addr)
            SEL_PA:  rdata = grp_rd[0];
            SEL_PB:  rdata = grp_rd[1];
            SEL_PC:  rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
            default: rdata = '0;
        endcase
    end

    a_r7_strobe_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_CTL && wdata[7] && wdata[2]) |=> (!pc_oe[0] && pc_oe[1] && pc_oe[2]));

    a_r1_reset_inputs: assert property (@(posedge clk)
        $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));

endmodule

// File: tb/hsp_port_tb_top.sv
module hsp_port_tb_top;

    typedef struct packed {
        logic       is_rd;
        logic [1:0] a;
        logic [7:0] wd;
        logic [7:0] pa;
        logic [7:0] pb;
        logic [7:0] pc;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h5A},  // R3 live input
        '{1'b1, 2'd1, 8'h00, 8'h00, 8'hC3, 8'h00, 8'hC3},  // R2
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h96, 8'h96},  // R6
        '{1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},  // R2 control reads 0
        '{1'b0, 2'd3, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00},  // R4 all out
        '{1'b0, 2'd0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b0, 2'd1, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b0, 2'd2, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h3C},  // R3 readback
        '{1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5},  // R3
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0},  // R6
        '{1'b0, 2'd3, 8'h89, 8'h00, 8'h00, 8'h00, 8'h00},  // R4
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h5A},  // R6
        '{1'b1, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},  // R4 latch cleared
        '{1'b0, 2'd3, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b0, 2'd3, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00},  // R5 set bit 2
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hA0, 8'hA4},  // R5 R6
        '{1'b0, 2'd3, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00},  // R5 clear bit 2
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hA3, 8'hA0}   // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hsp_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 pc_out", pc_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            pa_in = VEC[i].pa; pb_in = VEC[i].pb; pc_in = VEC[i].pc;
            if (VEC[i].is_rd) begin
                bus_read(VEC[i].a, v);
                check($sformatf("R2/R3/R4/R5/R6 vec %0d", i), v, VEC[i].exp);
            end else begin
                bus_write(VEC[i].a, VEC[i].wd);
            end
        end

        // R3 drive values in plain output mode
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h6D);
        check("R3 pa_out", pa_out, 8'h6D);
        check("R3 pa_oe", pa_oe, 8'hFF);
        check("R4 pb cleared", pb_out, 8'h00);

        // R7 R8 R9 strobed input on group A
        pc_in = 8'h10;
        bus_write(2'd3, 8'hBB);
        check("R7 oe A strobed", pc_oe, 8'h60);
        check("R8 ibf idle", {7'd0, pc_out[5]}, 8'd0);
        bus_write(2'd3, 8'h09);  // R5 enable group A
        check("R9 intr idle", {7'd0, pc_out[6]}, 8'd0);
        pa_in = 8'h77; pc_in = 8'h00;
        @(negedge clk);
        check("R8 ibf set", {7'd0, pc_out[5]}, 8'd1);
        check("R9 intr while low", {7'd0, pc_out[6]}, 8'd0);
        pa_in = 8'h11; pc_in = 8'h10;
        #1 check("R9 intr on rise", {7'd0, pc_out[6]}, 8'd1);
        bus_read(2'd0, v);
        check("R8 latched data", v, 8'h77);
        check("R9 ibf cleared", {7'd0, pc_out[5]}, 8'd0);
        check("R9 intr cleared", {7'd0, pc_out[6]}, 8'd0);
        bus_write(2'd3, 8'h08);  // disable
        pa_in = 8'h42; pc_in = 8'h00;
        @(negedge clk);
        pa_in = 8'h99; pc_in = 8'h10;
        #1 check("R9 intr disabled", {7'd0, pc_out[6]}, 8'd0);
        check("R8 ibf disabled run", {7'd0, pc_out[5]}, 8'd1);
        bus_read(2'd0, v);
        check("R8 second latch", v, 8'h42);

        // R7 R10 R11 strobed output on group B
        pc_in = 8'h01;
        bus_write(2'd3, 8'h9D);
        check("R7 oe B strobed", pc_oe, 8'h06);
        check("R10 obf idle high", {7'd0, pc_out[1]}, 8'd1);
        bus_write(2'd3, 8'h01);  // R5 enable group B
        bus_write(2'd1, 8'hE7);
        check("R10 pb_out", pb_out, 8'hE7);
        check("R10 pb_oe", pb_oe, 8'hFF);
        check("R10 obf low", {7'd0, pc_out[1]}, 8'd0);
        pc_in = 8'h00;
        @(negedge clk);
        check("R10 ack clears", {7'd0, pc_out[1]}, 8'd1);
        check("R11 no intr during ack", {7'd0, pc_out[2]}, 8'd0);
        pc_in = 8'h01;
        @(negedge clk);
        check("R11 intr set", {7'd0, pc_out[2]}, 8'd1);
        @(negedge clk);
        check("R11 intr holds", {7'd0, pc_out[2]}, 8'd1);
        bus_write(2'd1, 8'h18);
        check("R11 write clears intr", {7'd0, pc_out[2]}, 8'd0);
        check("R10 obf low again", {7'd0, pc_out[1]}, 8'd0);
        bus_read(2'd2, v);
        check("R6 C status read", v, 8'h01);
        bus_write(2'd3, 8'h9D);
        check("R4 handshake idle", {7'd0, pc_out[1]}, 8'd1);
        check("R4 pb latch cleared", pb_out, 8'h00);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pb_oe after reset", pb_oe, 8'h00);
        check("R1 pc_oe after reset", pc_oe, 8'h00);
        rst_n = 1'b1;
        pa_in = 8'h3E;
        bus_read(2'd0, v);
        check("R1 A input after reset", v, 8'h3E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule